// File: doc/BRIEF.md
# Free-Running ADC Sample Accumulator

This block collects converted samples from an analog-to-digital converter and keeps two registers: a running sum and a sample counter. Every strobed sample is zero-extended and added to the sum, and the counter advances by one. Neither register is ever cleared by a read. Both wrap freely at their widths. The samples are unsigned 12-bit codes, with zero volts at mid-scale, and they arrive at a nominal rate of one per microsecond.

A host reads both fields as a single packed 32-bit word, at any time, by pulsing a read strobe. To get the number of samples taken since its previous read, the host subtracts the two count fields modulo 2^10. To get the sum of those samples, it subtracts the two sum fields modulo 2^22. It divides the second result by the first to obtain the average code over that interval. This works as long as fewer than 1024 samples arrive between two reads. A read copies the word into a holding register, so the value returned is one coherent pair that accumulation cannot change afterwards.

Top module: `adc_sum_snapshot`

## Requirements
- R1: A synchronous active-high reset clears the sum, the count and the held word to zero.
- R2: Each cycle with `smp_valid` high adds the 12-bit `smp_code`, zero-extended, to the 22-bit sum modulo 2^22.
- R3: Each cycle with `smp_valid` high increments the 10-bit count by one modulo 2^10, in the same cycle that the sum updates.
- R4: The held word places the sum in bits 31:10 and the count in bits 9:0.
- R5: While `smp_valid` is low, `smp_code` has no effect on the sum or the count.
- R6: A read never clears or alters the sum or the count. Back-to-back reads with no samples between them return identical words.
- R7: `snap_word` changes only in the cycle after a `rd_strobe` and holds its value otherwise.
- R8: A read whose strobe coincides with a sample returns the word from before that sample. The sample appears in full, in both fields, at the next read.
- R9: For fewer than 1024 samples between two reads, the modular differences of the two fields equal the number of samples and their sum, including when both fields wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe, one cycle per converted sample |
| smp_code | input | 12 | Unsigned sample code, mid-scale equals zero input |
| rd_strobe | input | 1 | Host read request; copies the live word into the holding register |
| snap_word | output | 32 | Held word: sum in bits 31:10, count in bits 9:0 |

## Verification
The bench builds the block with its default widths: a 12-bit sample, a 22-bit sum and a 10-bit count. With these widths, 1000 full-scale samples (code 4095) bring the count past 1023 and the sum past 2^22 - 1 inside one interval. This lets the modular differences be checked across a wrap of both fields. The narrow 10-bit count also keeps a full wrap well within the run length. The bench also applies a sample and a read strobe in the same cycle, and checks where that sample lands.

// File: rtl/adc_acc_pkg.sv
package adc_acc_pkg;

    localparam int DEF_SAMPLE_W = 12;
    localparam int DEF_SUM_W    = 22;
    localparam int DEF_CNT_W    = 10;

    // Where a read strobe stands relative to the sample update in one cycle
    typedef enum logic [1:0] {
        SNAP_IDLE    = 2'd0,
        SNAP_PLAIN   = 2'd1,
        SNAP_COLLIDE = 2'd2
    } snap_kind_e;

endpackage

// File: rtl/adc_acc_core.sv
module adc_acc_core #(
    parameter int SAMPLE_W = adc_acc_pkg::DEF_SAMPLE_W,
    parameter int SUM_W    = adc_acc_pkg::DEF_SUM_W,
    parameter int CNT_W    = adc_acc_pkg::DEF_CNT_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_code,
    output logic [SUM_W-1:0]    sum_q,
    output logic [CNT_W-1:0]    cnt_q
);

    logic [SUM_W-1:0] addend;

    generate
        if (SUM_W > SAMPLE_W) begin : g_widen
            assign addend = {{(SUM_W-SAMPLE_W){1'b0}}, in_code};
        end else begin : g_trim
            assign addend = in_code[SUM_W-1:0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            cnt_q <= '0;
        end else if (in_valid) begin
            sum_q <= sum_q + addend;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R1
    acc_reset_chk: assert property (@(posedge clk)
        rst |=> (sum_q == '0 && cnt_q == '0));

    // R2
    sum_step_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> sum_q == SUM_W'($past(sum_q) + $past(addend)));

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(sum_q) && $stable(cnt_q)));

endmodule

// File: rtl/adc_snap_hold.sv
module adc_snap_hold #(
    parameter int WORD_W = adc_acc_pkg::DEF_SUM_W + adc_acc_pkg::DEF_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  logic              smp_now,
    input  logic [WORD_W-1:0] live_word,
    output logic [WORD_W-1:0] held_word
);
    import adc_acc_pkg::*;

    snap_kind_e kind;

    always_comb begin
        unique case ({rd_req, smp_now})
            2'b10:   kind = SNAP_PLAIN;
            2'b11:   kind = SNAP_COLLIDE;
            default: kind = SNAP_IDLE;
        endcase
    end

    // Both plain and colliding reads take the pre-update word
    always_ff @(posedge clk) begin
        if (rst) begin
            held_word <= '0;
        end else begin
            unique case (kind)
                SNAP_PLAIN, SNAP_COLLIDE: held_word <= live_word;
                default:                  held_word <= held_word;
            endcase
        end
    end

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> $stable(held_word));

endmodule

// File: rtl/adc_sum_snapshot.sv
module adc_sum_snapshot #(
    parameter int SAMPLE_W = adc_acc_pkg::DEF_SAMPLE_W,
    parameter int SUM_W    = adc_acc_pkg::DEF_SUM_W,
    parameter int CNT_W    = adc_acc_pkg::DEF_CNT_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_valid,
    input  logic [SAMPLE_W-1:0]       smp_code,
    input  logic                      rd_strobe,
    output logic [SUM_W+CNT_W-1:0]    snap_word
);

    localparam int WORD_W = SUM_W + CNT_W;

    logic [SUM_W-1:0]  sum_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] live_word;

    adc_acc_core #(
        .SAMPLE_W(SAMPLE_W),
        .SUM_W   (SUM_W),
        .CNT_W   (CNT_W)
    ) u_core (
        .clk     (clk),
        .rst     (rst),
        .in_valid(smp_valid),
        .in_code (smp_code),
        .sum_q   (sum_q),
        .cnt_q   (cnt_q)
    );

    // R4: sum in the upper field, count in the lower
    assign live_word = {sum_q, cnt_q};

    adc_snap_hold #(
        .WORD_W(WORD_W)
    ) u_hold (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_strobe),
        .smp_now  (smp_valid),
        .live_word(live_word),
        .held_word(snap_word)
    );

    // R8
    snap_pre_update_chk: assert property (@(posedge clk) disable iff (rst)
        rd_strobe |=> snap_word == $past({sum_q, cnt_q}));

    // R6
    read_no_disturb_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && !smp_valid) |=> ($stable(sum_q) && $stable(cnt_q)));

endmodule

// File: tb/test_adc_sum_snapshot.sv
module test_adc_sum_snapshot;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 8;
    localparam logic [11:0] VEC [NV] = '{12'd2048, 12'd0, 12'd4095, 12'd1,
                                         12'd1234, 12'd2047, 12'd3000, 12'd777};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_code = '0;
    logic        rd_strobe = 1'b0;
    logic [31:0] snap_word;

    int n_chk = 0;
    int n_bad = 0;
    logic [21:0] msum = '0;
    logic [9:0]  mcnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sum_snapshot i_adc_sum_snapshot (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .smp_code (smp_code),
        .rd_strobe(rd_strobe),
        .snap_word(snap_word)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic push(input logic [11:0] v);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_code  = v;
        @(negedge clk);
        smp_valid = 1'b0;
        msum = msum + 22'(v);
        mcnt = mcnt + 10'd1;
    endtask

    task automatic do_read(output logic [31:0] w);
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        w = snap_word;
    endtask

    initial begin
        logic [31:0] w0, w1, w2;
        repeat (3) @(negedge clk);
        // R1: reset state visible directly and through a read
        check("R1 held after reset", snap_word, 32'h0);
        rst = 1'b0;
        do_read(w0);
        check("R1 read after reset", w0, 32'h0);

        // R2 R3 R4: table walk, read after each sample
        for (int i = 0; i < NV; i++) begin
            push(VEC[i]);
            do_read(w1);
            check("R2 sum field", {10'h0, w1[31:10]}, {10'h0, msum});
            check("R3 count field", {22'h0, w1[9:0]}, {22'h0, mcnt});
            check("R4 packing", w1, {msum, mcnt});
        end

        // R5: code toggles while valid low
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            smp_code = 12'(i * 911 + 3);
        end
        do_read(w1);
        check("R5 ignored code", w1, {msum, mcnt});

        // R6: back-to-back reads identical, no clearing
        do_read(w2);
        check("R6 repeat read", w2, w1);
        push(12'd5);
        do_read(w2);
        check("R6 no clear on read", w2, {msum, mcnt});

        // R7: held word does not follow new samples until read
        w0 = snap_word;
        push(12'd100);
        push(12'd200);
        check("R7 held without read", snap_word, w0);

        // R8: sample coincident with read
        w0 = {msum, mcnt};
        @(negedge clk);
        smp_valid = 1'b1; smp_code = 12'd321; rd_strobe = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0; rd_strobe = 1'b0;
        msum = msum + 22'd321; mcnt = mcnt + 10'd1;
        check("R8 colliding read excludes", snap_word, w0);
        do_read(w1);
        check("R8 next read includes", w1, {msum, mcnt});

        // R9: wrap of both fields within one interval of 1000 samples
        repeat (1000) push(12'd4095);
        do_read(w1);
        repeat (1000) push(12'd4095);
        do_read(w2);
        check("R9 count diff", {22'h0, 10'(w2[9:0] - w1[9:0])}, 32'd1000);
        check("R9 sum diff", {10'h0, 22'(w2[31:10] - w1[31:10])}, 32'd4095000);
        check("R9 both wrapped", {31'h0, (w2[9:0] < w1[9:0]) && (w2[31:10] < w1[31:10])}, 32'd1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule